// File: doc/BRIEF.md
# Time-Division Multiplexed Bus Switch

The block connects a set of 32-bit one-way bus segments between processor ports. Time is divided into a repeating schedule of slots. A table, loaded through a configuration write port, says for each slot which single port is the source and which ports receive its word. Nothing is negotiated at run time. A port gets exactly the share of the link that the table gives it. Giving a fast stream more slots per period than a slow one sets its rate.

Each table entry holds an enable bit, a source port index and a destination bitmask. One entry can feed one destination or copy the same word to several destinations. Software writes a shadow copy of the table. That copy becomes the running schedule as a whole at the moment the slot counter wraps, so a slot never runs with a partly updated entry. The current slot number is an output, so the processors can line up their traffic with the schedule.

Top module: `tdm_bus_switch`

## Requirements
- R1: The slot number starts at 0 after reset, rises by one every clock, and returns to 0 after slot SLOTS-1.
- R2: Reset clears every entry of both the shadow and running tables to idle. It also drives all out_valid bits and all out_data words to zero.
- R3: Suppose the running entry for slot s has the enable bit set, a source index k, and bit d set in its destination mask. Then on the clock edge that ends slot s, out_data word d takes in_data word k and out_valid bit d takes in_valid bit k. Port p uses in_data/out_data bits [p*32 +: 32]. A source may name itself as a destination.
- R4: If a mask has several bits set, every selected output carries the same word in the same cycle.
- R5: A slot whose entry has the enable bit clear, or whose mask is all zero, leaves every output invalid with zero data, whatever the inputs are.
- R6: An output whose bit is clear in the current mask is invalid and zero. This holds even when other ports present valid words.
- R7: A table write lands in the shadow table only. The running schedule keeps its old entry until the next wrap from slot SLOTS-1 to slot 0, and uses the new entry from then on.
- R8: A table write accepted on the same edge as a wrap misses that wrap. It takes effect at the following wrap.
- R9: If the scheduled source has in_valid low, its destinations stay invalid with zero data.
- R10: A source given several slots in one period delivers one word per granted slot, so its rate scales with its slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | $clog2(SLOTS) | Slot whose entry is written |
| cfg_src | input | $clog2(NPORTS) | Source port index for the entry |
| cfg_mask | input | NPORTS | Destination bitmask, bit d selects port d |
| cfg_en | input | 1 | Entry enable; clear makes the slot idle |
| in_data | input | NPORTS*DW | Words offered by each port, port p at [p*DW +: DW] |
| in_valid | input | NPORTS | Word-present flag per input port |
| out_data | output | NPORTS*DW | Registered words delivered to each port |
| out_valid | output | NPORTS | Registered word-present flag per output port |
| slot_idx | output | $clog2(SLOTS) | Current slot number |

## Verification
The bench builds the switch with its default parameters: four ports, 32-bit words and an eight-slot period. Eight slots leave room to keep unicast, multicast, disabled, empty-mask and loopback entries in one table while still programming a source into every other slot for the rate check. With four ports, one multicast mask can reach three destinations while a fourth port stays unselected. The period is short, so both shadow-update cases can be seen within a few periods: a write in mid-period, and a write on the wrap edge itself.

// File: rtl/tdm_sw_pkg.sv
package tdm_sw_pkg;
  // Index width that stays at least one bit for a count of one.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned SW = tdm_sw_pkg::idx_w(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  assign wrap = (slot == LAST);

  always_ff @(posedge clk) begin
    if (rst)       slot <= '0;
    else if (wrap) slot <= '0;
    else           slot <= slot + SW'(1);
  end
endmodule

// File: rtl/tdm_sched_table.sv
module tdm_sched_table #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned PW = tdm_sw_pkg::idx_w(NPORTS),
  localparam int unsigned SW = tdm_sw_pkg::idx_w(SLOTS),
  localparam int unsigned EW = NPORTS + PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [EW-1:0] wentry,
  input  logic          wrap,
  input  logic [SW-1:0] raddr,
  output logic [EW-1:0] rentry
);
  logic [EW-1:0] shadow [SLOTS];
  logic [EW-1:0] active [SLOTS];

  // Software side: one write port into the shadow copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) shadow[i] <= '0;
    end else if (we) begin
      shadow[waddr] <= wentry;
    end
  end

  // Running side: whole-table swap at the period boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) active[i] <= '0;
    end else if (wrap) begin
      for (int i = 0; i < SLOTS; i++) active[i] <= shadow[i];
    end
  end

  assign rentry = active[raddr];
endmodule

// File: rtl/tdm_crossbar.sv
module tdm_crossbar #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DW     = 32,
  localparam int unsigned PW = tdm_sw_pkg::idx_w(NPORTS),
  localparam int unsigned EW = NPORTS + PW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EW-1:0]        entry,
  input  logic [NPORTS*DW-1:0] in_data,
  input  logic [NPORTS-1:0]    in_valid,
  output logic [NPORTS*DW-1:0] out_data,
  output logic [NPORTS-1:0]    out_valid
);
  localparam int unsigned SRC_LSB = NPORTS;
  localparam int unsigned EN_BIT  = NPORTS + PW;
  localparam logic [PW:0] NP_L    = (PW + 1)'(NPORTS);

  logic [NPORTS-1:0] mask;
  logic [PW-1:0]     src;
  logic              en;
  logic              sel_v;
  logic [DW-1:0]     sel_d;

  assign mask = entry[NPORTS-1:0];
  assign src  = entry[SRC_LSB +: PW];
  assign en   = entry[EN_BIT];

  // One source mux shared by all destinations.
  always_comb begin
    sel_v = 1'b0;
    sel_d = '0;
    if (en && ({1'b0, src} < NP_L)) begin
      sel_v = in_valid[src];
      sel_d = in_data[int'(src)*DW +: DW];
    end
  end

  for (genvar d = 0; d < NPORTS; d++) begin : g_dest
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[d]          <= 1'b0;
        out_data[d*DW +: DW]  <= '0;
      end else if (mask[d] && sel_v) begin
        out_valid[d]          <= 1'b1;
        out_data[d*DW +: DW]  <= sel_d;
      end else begin
        out_valid[d]          <= 1'b0;
        out_data[d*DW +: DW]  <= '0;
      end
    end
  end
endmodule

// File: rtl/tdm_bus_switch.sv
module tdm_bus_switch #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned PW = tdm_sw_pkg::idx_w(NPORTS),
  localparam int unsigned SW = tdm_sw_pkg::idx_w(SLOTS),
  localparam int unsigned EW = NPORTS + PW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [SW-1:0]        cfg_slot,
  input  logic [PW-1:0]        cfg_src,
  input  logic [NPORTS-1:0]    cfg_mask,
  input  logic                 cfg_en,
  input  logic [NPORTS*DW-1:0] in_data,
  input  logic [NPORTS-1:0]    in_valid,
  output logic [NPORTS*DW-1:0] out_data,
  output logic [NPORTS-1:0]    out_valid,
  output logic [SW-1:0]        slot_idx
);
  logic          wrap;
  logic [EW-1:0] cur_entry;

  tdm_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .slot (slot_idx),
    .wrap (wrap)
  );

  tdm_sched_table #(.NPORTS(NPORTS), .SLOTS(SLOTS)) u_tab (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .waddr  (cfg_slot),
    .wentry ({cfg_en, cfg_src, cfg_mask}),
    .wrap   (wrap),
    .raddr  (slot_idx),
    .rentry (cur_entry)
  );

  tdm_crossbar #(.NPORTS(NPORTS), .DW(DW)) u_xbar (
    .clk       (clk),
    .rst       (rst),
    .entry     (cur_entry),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/tdm_bus_switch_chk.sv
module tdm_bus_switch_chk #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned SW = tdm_sw_pkg::idx_w(SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [SW-1:0]        slot_idx,
  input logic [NPORTS-1:0]    in_valid,
  input logic [NPORTS*DW-1:0] out_data,
  input logic [NPORTS-1:0]    out_valid
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam logic [SW-1:0] ONE  = SW'(1);

  a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
    (slot_idx != LAST) |=> (slot_idx == $past(slot_idx) + ONE));

  a_r1_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    (slot_idx == LAST) |=> (slot_idx == '0));

  a_r2_reset_idle: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && out_data == '0 && slot_idx == '0));

  a_r9_needs_source: assert property (@(posedge clk) disable iff (rst)
    (out_valid != '0) |-> ($past(in_valid) != '0));

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !out_valid[p] |-> (out_data[p*DW +: DW] == '0));
    for (genvar q = p + 1; q < NPORTS; q++) begin : g_pair
      a_r4_same_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid[p] && out_valid[q]) |->
          (out_data[p*DW +: DW] == out_data[q*DW +: DW]));
    end
  end
endmodule

bind tdm_bus_switch tdm_bus_switch_chk #(
  .NPORTS(NPORTS), .DW(DW), .SLOTS(SLOTS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slot_idx  (slot_idx),
  .in_valid  (in_valid),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/tdm_bus_switch_bench.sv
`timescale 1ns/1ps
module tdm_bus_switch_bench;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int NS = 8;
  localparam int PW = 2;
  localparam int SW = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_we = 1'b0;
  logic [SW-1:0]      cfg_slot = '0;
  logic [PW-1:0]      cfg_src = '0;
  logic [NP-1:0]      cfg_mask = '0;
  logic               cfg_en = 1'b0;
  logic [NP*DW-1:0]   in_data = '0;
  logic [NP-1:0]      in_valid = '0;
  logic [NP*DW-1:0]   out_data;
  logic [NP-1:0]      out_valid;
  logic [SW-1:0]      slot_idx;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tdm_bus_switch #(.NPORTS(NP), .DW(DW), .SLOTS(NS)) u_tdm_bus_switch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_src(cfg_src), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
    .in_data(in_data), .in_valid(in_valid), .out_data(out_data),
    .out_valid(out_valid), .slot_idx(slot_idx)
  );

  function automatic logic [DW-1:0] word(input int p, input int k);
    return 32'hC0DE_0000 | DW'(p << 8) | DW'(k);
  endfunction

  function automatic logic [NP*DW-1:0] all_words(input int k);
    logic [NP*DW-1:0] v = '0;
    for (int p = 0; p < NP; p++) v[p*DW +: DW] = word(p, k);
    return v;
  endfunction

  function automatic logic [NP*DW-1:0] place(input logic [NP-1:0] m, input logic [DW-1:0] w);
    logic [NP*DW-1:0] v = '0;
    for (int p = 0; p < NP; p++) if (m[p]) v[p*DW +: DW] = w;
    return v;
  endfunction

  task automatic expect_out(input string tag, input logic [NP-1:0] ev, input logic [NP*DW-1:0] ed);
    tests++;
    if (out_valid !== ev || out_data !== ed) begin
      fails++;
      $display("FAIL %s: out_valid=%b out_data=%h expected %b %h", tag, out_valid, out_data, ev, ed);
    end
  endtask

  // Guarded write: never lands on the wrap edge.
  task automatic write_entry(input int s, input int src, input logic [NP-1:0] m, input logic en);
    if (slot_idx == SW'(NS - 1)) @(negedge clk);
    cfg_we = 1'b1; cfg_slot = SW'(s); cfg_src = PW'(src); cfg_mask = m; cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic raw_write(input int s, input int src, input logic [NP-1:0] m, input logic en);
    cfg_we = 1'b1; cfg_slot = SW'(s); cfg_src = PW'(src); cfg_mask = m; cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_wrap();
    @(negedge clk);
    while (slot_idx != '0) @(negedge clk);
  endtask

  task automatic run_slot(input int s, input logic [NP-1:0] iv, input logic [NP*DW-1:0] id);
    while (slot_idx != SW'(s)) @(negedge clk);
    in_valid = iv; in_data = id;
    @(negedge clk);
    in_valid = '0; in_data = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tests++;
    if (slot_idx !== '0) begin
      fails++;
      $display("FAIL R1 reset slot: slot_idx=%0d expected 0", slot_idx);
    end
    expect_out("R2 reset outputs", '0, '0);
    run_slot(2, '1, all_words(1));
    expect_out("R2 cleared table idles", '0, '0);
  endtask

  task automatic t_counter();
    logic [SW-1:0] prev;
    prev = slot_idx;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      tests++;
      if (slot_idx !== SW'((int'(prev) + 1) % NS)) begin
        fails++;
        $display("FAIL R1 slot step: slot_idx=%0d expected %0d", slot_idx, (int'(prev) + 1) % NS);
      end
      prev = slot_idx;
    end
  endtask

  task automatic t_program();
    write_entry(2, 1, 4'b0100, 1'b1);
    write_entry(3, 0, 4'b1011, 1'b1);
    write_entry(4, 2, 4'b0001, 1'b0);
    write_entry(5, 3, 4'b0000, 1'b1);
    write_entry(6, 3, 4'b1000, 1'b1);
    wait_wrap();
  endtask

  task automatic t_unicast();
    run_slot(2, '1, all_words(2));
    expect_out("R3/R6 unicast 1->2", 4'b0100, place(4'b0100, word(1, 2)));
  endtask

  task automatic t_multicast();
    run_slot(3, '1, all_words(3));
    expect_out("R4 multicast 0->0,1,3", 4'b1011, place(4'b1011, word(0, 3)));
  endtask

  task automatic t_disabled();
    run_slot(4, '1, all_words(4));
    expect_out("R5 enable clear", '0, '0);
    run_slot(5, '1, all_words(5));
    expect_out("R5 empty mask", '0, '0);
  endtask

  task automatic t_src_invalid();
    run_slot(2, 4'b1101, all_words(6));
    expect_out("R9 source not valid", '0, '0);
  endtask

  task automatic t_loopback();
    run_slot(6, '1, all_words(7));
    expect_out("R3 loopback 3->3", 4'b1000, place(4'b1000, word(3, 7)));
  endtask

  task automatic t_shadow_mid();
    while (slot_idx != SW'(1)) @(negedge clk);
    raw_write(5, 2, 4'b0001, 1'b1);
    run_slot(5, '1, all_words(8));
    expect_out("R7 old entry until wrap", '0, '0);
    run_slot(5, '1, all_words(9));
    expect_out("R7 new entry after wrap", 4'b0001, place(4'b0001, word(2, 9)));
  endtask

  task automatic t_shadow_last();
    while (slot_idx != SW'(NS - 1)) @(negedge clk);
    raw_write(6, 0, 4'b0010, 1'b1);
    run_slot(6, '1, all_words(10));
    expect_out("R8 wrap-edge write not yet active", 4'b1000, place(4'b1000, word(3, 10)));
    run_slot(6, '1, all_words(11));
    expect_out("R8 active one period later", 4'b0010, place(4'b0010, word(0, 11)));
  endtask

  task automatic t_bandwidth();
    int got1 = 0;
    int other = 0;
    for (int s = 0; s < NS; s++) begin
      if (s % 2 == 0) write_entry(s, 0, 4'b0010, 1'b1);
      else            write_entry(s, 1, 4'b0000, 1'b0);
    end
    wait_wrap();
    in_valid = '1; in_data = all_words(12);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      if (out_valid[1] && out_data[DW +: DW] == word(0, 12)) got1++;
      if ((out_valid & 4'b1101) != '0) other++;
    end
    in_valid = '0; in_data = '0;
    tests++;
    if (got1 != 4 || other != 0) begin
      fails++;
      $display("FAIL R10 slots per period: port1 words=%0d others=%0d expected 4 0", got1, other);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_counter();
    t_program();
    t_unicast();
    t_multicast();
    t_disabled();
    t_src_invalid();
    t_loopback();
    t_shadow_mid();
    t_shadow_last();
    t_bandwidth();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule